// File: doc/BRIEF.md
# Byte-Wide SPI Master with Device Interrupt Collector

This block is an SPI master that sits on an 8-bit microprocessor bus. It is accessed through four byte-wide register slots. Two address lines pick the slot. An access is qualified by an active-high select, an active-low select and the bus clock phase.

Writing a byte to the data slot starts an 8-bit, MSB-first transfer in SPI mode 0. The shift clock is the system clock divided by a 4-bit programmable ratio. The block drives four active-low slave selects. It samples MISO from whichever slave is selected, since each slave has its own MISO pin. A transfer-complete flag raises a maskable interrupt.

Four active-high device interrupt inputs are each gated by their own enable bit. They are merged with the transfer interrupt onto one active-low interrupt output. The host can read the raw levels of these inputs.

Top module: `spib_master`

## Requirements
- R1: The bus is qualified only when `bus_cs_hi`=1, `bus_cs_lo_n`=0 and `bus_phase`=1. `bus_rdata_oe` is 1 exactly then. Register side effects happen once, on the first clock of a qualified window, and never outside one.
- R2: After reset, all selects read 1, the enables, divisor and control bit read 0, the transfer flag is clear, `irq_n`=1 and `spi_sclk`=0.
- R3: The slots are decoded by `bus_addr`:
  - Slot 0 is the data byte.
  - Slot 1 reads as {flag bit 7, busy bit 6, zeros} and writes the control byte.
  - Slot 2 reads as {device input levels in 7:4, divisor in 3:0}. On a write, only bits 3:0 are stored.
  - Slot 3 reads and writes {enables in 7:4, selects in 3:0}, where select bit n drives `spi_sel_n[n]`.
- R4: For a divisor field d, the SCLK period is N = max(d,1)+1 system clocks. SCLK is low for ceil(N/2) clocks and then high for floor(N/2) clocks in each bit. SCLK idles low.
- R5: A write to slot 0 while idle sends that byte MSB first on `spi_mosi`. `spi_mosi` is stable at each SCLK rising edge, and there are exactly 8 rising edges. Status bit 6 is 1 for the whole transfer.
- R6: MISO is sampled on each SCLK rising edge from the lowest-numbered slave whose select is 0. With no select at 0, the sampled bits are 0. The received byte is read back from slot 0.
- R7: A slot-0 write during a transfer does not change the byte being shifted out.
- R8: Status bit 7 sets when a transfer ends. It clears on a read or a write of slot 0. If completion and a clear fall on the same cycle, the completion wins.
- R9: `irq_n` is 0 exactly when (status bit 7 AND control bit 7) OR (any `dev_irq[n]` AND enable n). The device path responds to `dev_irq` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_hi | input | 1 | Active-high chip select |
| bus_cs_lo_n | input | 1 | Active-low chip select |
| bus_phase | input | 1 | Bus clock phase, access when high |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 2 | Register slot |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 1 | Read data drive enable (low = released) |
| spi_sclk | output | 1 | Shift clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 4 | Serial data in, one per slave |
| spi_sel_n | output | 4 | Slave selects, active low |
| dev_irq | input | 4 | Device interrupts, active high |
| irq_n | output | 1 | Merged interrupt, active low |

## Verification
The assertions check on every cycle that:
- the selects and divisor never change outside a qualified access;
- SCLK stays low while idle, and the divider count stays inside its ratio;
- busy drops right after completion;
- a data-slot access clears the flag unless completion coincides with it;
- a pending, enabled transfer flag always holds `irq_n` low.

Only the bench's scenarios show the rest:
- the exact SCLK period and high time for each of the sixteen divisor codes;
- the MSB-first bit order on both lines;
- the lowest-index MISO choice when several slaves are selected;
- that a write during a transfer leaves the outgoing byte intact;
- the full 16x16 sweep of device levels against enables.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int DW   = 8;
  localparam int NSLV = 4;
  localparam int DIVW = 4;
  localparam int BITW = $clog2(DW);

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_DIV  = 2'd2,
    SLOT_SEL  = 2'd3
  } slot_e;
endpackage

// File: rtl/spib_clkdiv.sv
module spib_clkdiv
  import spib_pkg::*;
#(
  parameter int W = DIVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         sclk,
  output logic         smp,
  output logic         bit_end
);
  logic [W:0] ratio, half, cnt_q, cnt_d;

  always_comb begin
    ratio = (div == '0) ? (W+1)'(2) : ({1'b0, div} + (W+1)'(1));
    half  = (ratio + (W+1)'(1)) >> 1;
    smp     = run && (cnt_q == half - (W+1)'(1));
    bit_end = run && (cnt_q == ratio - (W+1)'(1));
    sclk    = run && (cnt_q >= half);
    if (!run || bit_end) cnt_d = '0;
    else                 cnt_d = cnt_q + (W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio)); // R4
endmodule

// File: rtl/spib_shifter.sv
module spib_shifter
  import spib_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          smp,
  input  logic          bit_end,
  input  logic          miso_bit,
  output logic          busy,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  logic            busy_q, busy_d, samp_q, samp_d;
  logic [DW-1:0]   sh_q, sh_d, rx_q, rx_d;
  logic [BITW-1:0] bitn_q, bitn_d;

  always_comb begin
    busy_d = busy_q;
    samp_d = samp_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    bitn_d = bitn_q;
    done   = busy_q && bit_end && (bitn_q == BITW'(DW-1));
    if (start) begin
      busy_d = 1'b1;
      sh_d   = tx_byte;
      bitn_d = '0;
    end else if (busy_q) begin
      if (smp) samp_d = miso_bit;
      if (bit_end) begin
        sh_d   = {sh_q[DW-2:0], samp_q};
        bitn_d = bitn_q + BITW'(1);
        if (done) begin
          busy_d = 1'b0;
          rx_d   = {sh_q[DW-2:0], samp_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      samp_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      bitn_q <= '0;
    end else begin
      busy_q <= busy_d;
      samp_q <= samp_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bitn_q <= bitn_d;
    end
  end

  assign busy    = busy_q;
  assign mosi    = sh_q[DW-1];
  assign rx_byte = rx_q;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R5
endmodule

// File: rtl/spib_regs.sv
module spib_regs
  import spib_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic            rd_stb,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic            busy,
  input  logic            done,
  input  logic [DW-1:0]   rx_byte,
  input  logic [NSLV-1:0] dev_irq,
  output logic [DW-1:0]   rdata,
  output logic [DIVW-1:0] div,
  output logic [NSLV-1:0] sel_n,
  output logic            start,
  output logic            irq_n
);
  logic [DIVW-1:0] div_q, div_d;
  logic [NSLV-1:0] sel_q, sel_d, ien_q, ien_d;
  logic            tc_q, tc_d, tie_q, tie_d;
  logic            data_hit;

  always_comb begin
    data_hit = (wr_stb || rd_stb) && (slot_e'(addr) == SLOT_DATA);
    start    = wr_stb && (slot_e'(addr) == SLOT_DATA) && !busy;
    div_d = div_q;
    sel_d = sel_q;
    ien_d = ien_q;
    tie_d = tie_q;
    if (wr_stb) begin
      case (slot_e'(addr))
        SLOT_CTRL: tie_d = wdata[DW-1];
        SLOT_DIV:  div_d = wdata[DIVW-1:0];
        SLOT_SEL:  {ien_d, sel_d} = wdata;
        default:   ;
      endcase
    end
    if (done)          tc_d = 1'b1;
    else if (data_hit) tc_d = 1'b0;
    else               tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '1;
      ien_q <= '0;
      tc_q  <= 1'b0;
      tie_q <= 1'b0;
    end else begin
      div_q <= div_d;
      sel_q <= sel_d;
      ien_q <= ien_d;
      tc_q  <= tc_d;
      tie_q <= tie_d;
    end
  end

  always_comb begin
    case (slot_e'(addr))
      SLOT_DATA: rdata = rx_byte;
      SLOT_CTRL: rdata = {tc_q, busy, 6'b0};
      SLOT_DIV:  rdata = {dev_irq, div_q};
      default:   rdata = {ien_q, sel_q};
    endcase
  end

  assign irq_n = !((tc_q && tie_q) || |(dev_irq & ien_q));
  assign div   = div_q;
  assign sel_n = sel_q;

  AST_TC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !done) |=> !tc_q); // R8
  AST_IRQ_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && tie_q) |-> !irq_n); // R9
endmodule

// File: rtl/spib_master.sv
module spib_master
  import spib_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs_hi,
  input  logic            bus_cs_lo_n,
  input  logic            bus_phase,
  input  logic            bus_rnw,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rdata_oe,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic [NSLV-1:0] spi_miso,
  output logic [NSLV-1:0] spi_sel_n,
  input  logic [NSLV-1:0] dev_irq,
  output logic            irq_n
);
  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  logic            acc, acc_q, first, wr_stb, rd_stb;
  logic            busy, done, start, smp, bit_end, miso_bit;
  logic [DW-1:0]   rx_byte, rdata;
  logic [DIVW-1:0] div;
  logic [NSLV-1:0] sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign acc    = bus_cs_hi && !bus_cs_lo_n && bus_phase;
  assign first  = acc && !acc_q;
  assign wr_stb = first && !bus_rnw;
  assign rd_stb = first && bus_rnw;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) acc_q <= 1'b0;
    else          acc_q <= acc;
  end

  always_comb begin
    miso_bit = 1'b0;
    for (int i = NSLV-1; i >= 0; i--)
      if (!sel_n[i]) miso_bit = spi_miso[i];
  end

  spib_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(bus_addr), .wdata(bus_wdata), .busy(busy), .done(done),
    .rx_byte(rx_byte), .dev_irq(dev_irq), .rdata(rdata), .div(div),
    .sel_n(sel_n), .start(start), .irq_n(irq_n)
  );

  spib_clkdiv u_div (
    .clk(clk), .rst_n(rst_i_n), .run(busy), .div(div),
    .sclk(spi_sclk), .smp(smp), .bit_end(bit_end)
  );

  spib_shifter u_sh (
    .clk(clk), .rst_n(rst_i_n), .start(start), .tx_byte(bus_wdata),
    .smp(smp), .bit_end(bit_end), .miso_bit(miso_bit), .busy(busy),
    .mosi(spi_mosi), .done(done), .rx_byte(rx_byte)
  );

  assign bus_rdata_oe = acc;
  assign bus_rdata    = acc ? rdata : '0;
  assign spi_sel_n    = sel_n;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !acc |=> ($stable(sel_n) && $stable(div))); // R1
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !spi_sclk); // R4
endmodule

// File: tb/spib_master_bench.sv
`timescale 1ns/1ps
module spib_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_hi = 1'b0, cs_lo_n = 1'b1, phase = 1'b0, rnw = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       oe, sclk, mosi, irq_n;
  logic [3:0] miso, sel_n;
  logic [3:0] dev_irq = 4'd0;

  int         n_chk = 0, n_bad = 0, cyc = 0, ridx = 0, hicnt = 0;
  int         rtime [0:7];
  logic [7:0] rmosi;
  logic [7:0] slv_pat [0:3];

  always #4 clk = ~clk;

  spib_master u_spib_master (
    .clk(clk), .rst_n(rst_n), .bus_cs_hi(cs_hi), .bus_cs_lo_n(cs_lo_n),
    .bus_phase(phase), .bus_rnw(rnw), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_rdata_oe(oe), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_sel_n(sel_n), .dev_irq(dev_irq), .irq_n(irq_n)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sclk) hicnt <= hicnt + 1;
  end

  always @(posedge sclk) begin
    if (ridx < 8) rtime[ridx] = cyc;
    rmosi = {rmosi[6:0], mosi};
    ridx  = ridx + 1;
  end

  always_comb
    for (int i = 0; i < 4; i++)
      miso[i] = (ridx < 8) ? slv_pat[i][7 - ridx] : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_hi = 1; cs_lo_n = 0; phase = 1; rnw = 0; addr = a; wdata = d;
    @(negedge clk);
    phase = 0; cs_hi = 0; rnw = 1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_hi = 1; cs_lo_n = 0; phase = 1; rnw = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    phase = 0; cs_hi = 0;
  endtask

  task automatic wait_tc();
    logic [7:0] s;
    for (int k = 0; k < 400; k++) begin
      bus_rd(2'd1, s);
      if (s[7]) break;
    end
  endtask

  function automatic logic [7:0] exp_rx(input logic [3:0] sn);
    for (int i = 0; i < 4; i++) if (!sn[i]) return slv_pat[i];
    return 8'h00;
  endfunction

  initial begin
    automatic int guard = 0;
    while (guard < 150000) begin @(posedge clk); guard++; end
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", guard);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 4; i++) slv_pat[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 irq_n", irq_n, 1);
    chk("R2 sclk", sclk, 0);
    chk("R2 sel_n pins", sel_n, 4'hF);
    bus_rd(2'd3, r); chk("R2 slot3", r, 8'h0F);
    bus_rd(2'd1, r); chk("R2 status", r, 8'h00);
    bus_rd(2'd2, r); chk("R2 slot2", r, 8'h00);

    // R1 qualification sweep
    for (int q = 0; q < 8; q++) begin
      @(negedge clk);
      cs_hi = q[0]; cs_lo_n = q[1]; phase = q[2]; rnw = 1;
      #1 chk("R1 oe", oe, (q[0] && !q[1] && q[2]) ? 1 : 0);
    end
    @(negedge clk); cs_hi = 0; cs_lo_n = 1; phase = 0;
    // R1 write without phase must not land
    @(negedge clk); cs_hi = 1; cs_lo_n = 0; phase = 0; rnw = 0; addr = 3; wdata = 8'h50;
    @(negedge clk); @(negedge clk); cs_hi = 0; rnw = 1;
    bus_rd(2'd3, r); chk("R1 unqualified write ignored", r, 8'h0F);

    // R3/R9 device interrupt sweep
    for (int en = 0; en < 16; en++) begin
      bus_wr(2'd3, {en[3:0], 4'hF});
      bus_rd(2'd3, r); chk("R3 slot3 readback", r, {en[3:0], 4'hF});
      for (int d = 0; d < 16; d++) begin
        dev_irq = d[3:0];
        #1 chk("R9 device irq", irq_n, ((en & d) != 0) ? 0 : 1);
        bus_rd(2'd2, r); chk("R3 slot2 levels", r[7:4], d);
      end
    end
    dev_irq = 0;
    bus_wr(2'd3, 8'h0F);

    // R4/R5/R6 divisor sweep
    for (int d = 0; d < 16; d++) begin
      automatic int n = (d == 0) ? 2 : d + 1;
      automatic logic [7:0] tx = 8'(d * 29 + 8'h3C);
      automatic logic [3:0] sn = ~(4'b1 << (d % 4));
      for (int i = 0; i < 4; i++) slv_pat[i] = 8'(8'hA5 ^ (d * 17 + i * 59));
      bus_wr(2'd2, 8'hF0 | 8'(d));
      bus_rd(2'd2, r); chk("R3 divisor", r[3:0], d);
      bus_wr(2'd3, {4'h0, sn});
      ridx = 0; hicnt = 0;
      bus_wr(2'd0, tx);
      bus_rd(2'd1, r); chk("R5 busy bit", r, 8'h40);
      wait_tc();
      chk("R5 edge count", ridx, 8);
      chk("R5 mosi byte", rmosi, tx);
      chk("R4 period", rtime[1] - rtime[0], n);
      chk("R4 span", rtime[7] - rtime[0], 7 * n);
      chk("R4 high time", hicnt, 8 * (n / 2));
      chk("R4 idle low", sclk, 0);
      bus_rd(2'd0, r); chk("R6 rx byte", r, exp_rx(sn));
      bus_rd(2'd1, r); chk("R8 cleared by read", r, 8'h00);
    end

    // R6 several or no slaves selected
    bus_wr(2'd2, 8'h01);
    for (int s = 0; s < 3; s++) begin
      automatic logic [3:0] sn = (s == 0) ? 4'b0101 : (s == 1) ? 4'b1111 : 4'b0000;
      for (int i = 0; i < 4; i++) slv_pat[i] = 8'(8'h1E + i * 8'h47);
      bus_wr(2'd3, {4'h0, sn});
      ridx = 0;
      bus_wr(2'd0, 8'h99);
      wait_tc();
      bus_rd(2'd0, r); chk("R6 select priority", r, exp_rx(sn));
    end

    // R8/R9 transfer interrupt
    bus_wr(2'd1, 8'h80);
    ridx = 0; bus_wr(2'd0, 8'h12); wait_tc();
    #1 chk("R9 tc irq low", irq_n, 0);
    bus_rd(2'd0, r);
    #1 chk("R8 read clears irq", irq_n, 1);
    ridx = 0; bus_wr(2'd0, 8'h34); wait_tc();
    ridx = 0; bus_wr(2'd0, 8'h56);
    bus_rd(2'd1, r); chk("R8 write clears flag", r, 8'h40);
    #1 chk("R8 write clears irq", irq_n, 1);
    wait_tc();
    chk("R8 mosi after restart", rmosi, 8'h56);
    bus_rd(2'd0, r);

    // R7 write during transfer ignored
    ridx = 0; bus_wr(2'd0, 8'hC3);
    bus_wr(2'd0, 8'h00);
    wait_tc();
    chk("R7 byte unchanged", rmosi, 8'hC3);
    chk("R7 edge count", ridx, 8);
    bus_rd(2'd1, r); chk("R8 set after end", r, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule